// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer Controller

This block sits behind a two-wire serial protocol engine in a byte-wide EEPROM model. The engine tells it when a write command begins, and with which word address. It then hands over each received data byte and finally signals the stop condition. The block gathers the bytes into an eight-byte page buffer. Nothing reaches the storage array until the stop arrives. The stop launches an internal write cycle: the buffered bytes are copied into a register-file array, and a busy flag stays high for a programmable number of clock cycles that stands in for the nonvolatile programming time.

A write-protect input blocks writes. Which addresses it covers depends on the array size. A 128-byte array is protected as a whole, while a larger array is protected only in its upper half. The protect input is sampled once for each byte, at the moment the byte is accepted. Once a write cycle has started, the protect input has no further effect on it. The block also maintains the current-address pointer that the engine uses for later reads. A combinational read port serves the engine's read path, and protection never affects that port.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and mem_we are low, cur_addr is zero and every array location reads zero.
- R2: A command loads cur_addr with cmd_addr. Each accepted byte goes to the slot named by cur_addr bits 2:0, and then only those three bits advance, wrapping from 7 to 0. The bits above bit 2 stay fixed, and every array write of the cycle goes to that one page.
- R3: When more than eight bytes arrive in one command, each slot holds the last byte written to it, and the cycle performs at most eight array writes.
- R4: The array does not change and mem_we stays low while bytes are being collected. Array writes happen only while busy is high.
- R5: A stop accepted after at least one byte raises busy on the next cycle, and busy stays high for exactly WR_CYCLES cycles. The filled slots are written in slot order 0 to 7 during the first eight of those cycles, each to address {page, slot}.
- R6: While busy is high, cmd_start, byte_vld and stop_evt are ignored: cur_addr does not change, no extra write happens, and busy falls at its normal time and stays low.
- R7: A stop that follows a command with no data bytes (a dummy write) leaves busy low, writes nothing, and leaves cur_addr equal to the loaded address.
- R8: With wp high, a byte aimed at the upper half of a 256-byte array (address bit 7 set) is not written, while a byte aimed at the lower half is written. In a 128-byte array no byte is written.
- R9: The wp input is sampled for each byte on the cycle that byte is accepted. A protected byte clears its slot's fill mark, while unprotected bytes of the same command are still written.
- R10: Raising wp after a write cycle has started neither aborts that cycle, nor shortens it, nor drops any of its writes.
- R11: rd_data always returns the array contents at rd_addr, whatever the level of wp.
- R12: After a command whose last byte lands on slot 7, cur_addr points to slot 0 of the same page.
- R13: If every byte of a command is protected, the stop still runs a full busy cycle of WR_CYCLES cycles, and the array is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Pulse: a write command begins with cmd_addr |
| cmd_addr | input | AW | Word address of the command |
| byte_vld | input | 1 | Pulse: byte_data holds one received data byte |
| byte_data | input | DW | Received data byte |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| wp | input | 1 | Write-protect level |
| rd_addr | input | AW | Read port address |
| rd_data | output | DW | Array contents at rd_addr |
| busy | output | 1 | Write cycle in progress |
| cur_addr | output | AW | Current-address pointer for the engine |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
Two cases are hard to reach from the ports. The first is a protect level that changes from byte to byte inside one page. The bench drives wp from a per-byte pattern while it streams the bytes, so protected and unprotected slots are mixed in one page, and it also raises wp partway through a running write cycle. The second is commands that arrive while busy is high. For these, the bench waits a few busy cycles and then pulses a command, a byte and a stop together. It confirms that the scoreboard sees no extra write, that the pointer is unchanged, and that busy falls exactly on time and stays low. A second, 128-byte instance receives the same stimulus, so the two protection ranges can be compared on one write.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int PAGE_BITS  = 3;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  // Next slot inside a page; the 3-bit sum wraps 7 -> 0.
  function automatic logic [PAGE_BITS-1:0] next_slot(input logic [PAGE_BITS-1:0] s);
    return s + 1'b1;
  endfunction

  // Protection decision for one byte: whole array, or upper half only.
  function automatic logic guarded(input logic wp_lvl, input logic top_bit, input logic whole);
    return wp_lvl && (whole || top_bit);
  endfunction
endpackage

// File: rtl/epw_mem.sv
module epw_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  // Read path never looks at write protection (R11).
  assign rdata = cells[raddr];
endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf
  import epw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter bit WHOLE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [AW-1:0]         load_addr,
  input  logic                  push,
  input  logic [DW-1:0]         push_data,
  input  logic                  stop_acc,
  input  logic                  wp,
  input  logic [PAGE_BITS-1:0]  rd_slot,
  output logic [DW-1:0]         slot_data,
  output logic [PAGE_BYTES-1:0] mask,
  output logic                  got_any,
  output logic                  active,
  output logic [AW-1:0]         cur_addr
);
  logic [DW-1:0]        slots [PAGE_BYTES];
  logic [PAGE_BITS-1:0] off;
  logic                 prot_now;

  assign off      = cur_addr[PAGE_BITS-1:0];
  assign prot_now = guarded(wp, cur_addr[AW-1], WHOLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      got_any  <= 1'b0;
      mask     <= '0;
      cur_addr <= '0;
    end else if (load) begin
      active   <= 1'b1;
      got_any  <= 1'b0;
      mask     <= '0;
      cur_addr <= load_addr;
    end else begin
      if (push) begin
        got_any                  <= 1'b1;
        mask[off]                <= !prot_now;        // R9
        cur_addr[PAGE_BITS-1:0]  <= next_slot(off);   // R2, R12
      end
      if (stop_acc) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[off] <= push_data;   // later bytes overwrite (R3)
  end

  assign slot_data = slots[rd_slot];
endmodule

// File: rtl/epw_write_seq.sv
module epw_write_seq
  import epw_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 2500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic [AW-PAGE_BITS-1:0] page,
  input  logic [PAGE_BYTES-1:0]   mask,
  input  logic [DW-1:0]           slot_data,
  output logic [PAGE_BITS-1:0]    slot_idx,
  output logic                    busy,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_waddr,
  output logic [DW-1:0]           mem_wdata
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          in_commit;
  logic          last_cyc;

  assign last_cyc = (cnt == CW'(WR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (last_cyc) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign slot_idx  = cnt[PAGE_BITS-1:0];
  assign in_commit = busy && (cnt < CW'(PAGE_BYTES));
  assign mem_we    = in_commit && mask[slot_idx];
  assign mem_waddr = {page, slot_idx};
  assign mem_wdata = slot_data;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 2500000   // must be at least PAGE_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          stop_evt,
  input  logic          wp,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [AW-1:0] cur_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int DEPTH = 1 << AW;
  localparam bit WHOLE = (DEPTH <= 128);

  // Named internal events, also used by the checker.
  logic                  load;
  logic                  push;
  logic                  stop_acc;
  logic                  launch;
  logic                  active;
  logic                  got_any;
  logic [PAGE_BYTES-1:0] mask;
  logic [PAGE_BITS-1:0]  slot_idx;
  logic [DW-1:0]         slot_data;

  assign load     = cmd_start && !busy;                 // R6
  assign push     = byte_vld && active && !busy;
  assign stop_acc = stop_evt && active && !busy;
  assign launch   = stop_acc && got_any;                // R7

  epw_page_buf #(.AW(AW), .DW(DW), .WHOLE(WHOLE)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (cmd_addr),
    .push      (push),
    .push_data (byte_data),
    .stop_acc  (stop_acc),
    .wp        (wp),
    .rd_slot   (slot_idx),
    .slot_data (slot_data),
    .mask      (mask),
    .got_any   (got_any),
    .active    (active),
    .cur_addr  (cur_addr)
  );

  epw_write_seq #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .page      (cur_addr[AW-1:PAGE_BITS]),
    .mask      (mask),
    .slot_data (slot_data),
    .slot_idx  (slot_idx),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  epw_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 2500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] cur_addr,
  input logic          stop_acc,
  input logic          got_any
);
  localparam int BW = $clog2(WR_CYCLES + 1) + 1;

  logic [BW-1:0] bcnt;
  logic [4:0]    wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      wcnt <= '0;
    end else if (busy) begin
      bcnt <= bcnt + 1'b1;
      wcnt <= wcnt + {4'd0, mem_we};
    end else begin
      bcnt <= '0;
      wcnt <= '0;
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);                                                  // R4
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BW'(WR_CYCLES));                           // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < BW'(WR_CYCLES));                                   // R5
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_acc && got_any) |=> busy);                                   // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_waddr[AW-1:3]));             // R2
  AST_CMD_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));                                       // R6
  AST_DUMMY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_acc && !got_any) |=> !busy);                                 // R7
  AST_WE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 5'd8);                                                     // R3
endmodule

bind eeprom_page_writer epw_checker #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .cur_addr  (cur_addr),
  .stop_acc  (stop_acc),
  .got_any   (got_any)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int WR = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       stop_evt = 1'b0;
  logic       wp = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data, rd_data_s;
  logic       busy, busy_s;
  logic [7:0] cur_addr;
  logic [6:0] cur_addr_s;
  logic       mem_we, mem_we_s;
  logic [7:0] mem_waddr, mem_wdata, mem_wdata_s;
  logic [6:0] mem_waddr_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] model [256];
  logic [7:0] exp_a [$];
  logic [7:0] exp_d [$];

  always #2 clk = ~clk;

  eeprom_page_writer #(.AW(8), .DW(8), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cur_addr(cur_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  eeprom_page_writer #(.AW(7), .DW(8), .WR_CYCLES(WR)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr[6:0]),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
    .rd_addr(rd_addr[6:0]), .rd_data(rd_data_s), .busy(busy_s), .cur_addr(cur_addr_s),
    .mem_we(mem_we_s), .mem_waddr(mem_waddr_s), .mem_wdata(mem_wdata_s));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: every array write is compared against the scoreboard queue (R5, R3, R8, R9).
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {mem_waddr, mem_wdata}, 32'h0);
      end else begin
        logic [7:0] ea, ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        chk(mem_waddr == ea && mem_wdata == ed, "R5 write addr/data",
            {mem_waddr, mem_wdata}, {ea, ed});
      end
    end
  end

  task automatic read_chk(input logic [7:0] a, input logic [7:0] expv, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == expv, req, rd_data, expv);
  endtask

  // Driver: one command with n bytes; wpm gives wp per byte.
  task automatic send_page(input logic [7:0] a, input int n, input logic [7:0] seed,
                           input logic [15:0] wpm, input bit wp_during, input bit poke,
                           input string req);
    logic [7:0] sd [8];
    logic [7:0] mk;
    logic [2:0] off;
    logic [7:0] exp_cur;
    int bc;
    mk  = '0;
    off = a[2:0];
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld  = 1'b1;
      byte_data = 8'(seed + i * 7);
      wp        = wpm[i];
      sd[off]   = byte_data;
      mk[off]   = !(wpm[i] && a[7]);
      off       = off + 3'd1;
      @(negedge clk);
    end
    byte_vld = 1'b0;
    wp       = 1'b0;
    // R4: collection phase has not touched the array.
    read_chk(a, model[a], "R4 array unchanged before stop");
    for (int s = 0; s < 8; s++) begin
      if (mk[s]) begin
        exp_a.push_back({a[7:3], 3'(s)});
        exp_d.push_back(sd[s]);
        model[{a[7:3], 3'(s)}] = sd[s];
      end
    end
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    bc = 0;
    while (busy && bc < 1000) begin
      bc++;
      if (wp_during && bc == 2) wp = 1'b1;
      if (poke && bc == 3) begin
        cmd_start = 1'b1; cmd_addr = 8'h00; byte_vld = 1'b1; stop_evt = 1'b1;
      end
      if (poke && bc == 4) begin
        cmd_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
      end
      @(negedge clk);
    end
    wp = 1'b0;
    chk(bc == ((n > 0) ? WR : 0), req, bc, (n > 0) ? WR : 0);
    exp_cur = {a[7:3], 3'(a[2:0] + 3'(n))};
    chk(cur_addr == exp_cur, {req, " cur_addr"}, cur_addr, exp_cur);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 busy/mem_we", {busy, mem_we}, 0);
    chk(cur_addr == 8'h00, "R1 cur_addr", cur_addr, 0);
    read_chk(8'h20, 8'h00, "R1 array zero");
    read_chk(8'hFF, 8'h00, "R1 array zero top");

    // R5/R2 basic page
    send_page(8'h20, 3, 8'h11, 16'h0, 1'b0, 1'b0, "R5 busy length");
    read_chk(8'h21, model[8'h21], "R5 data stored");
    rd_addr = 8'h22; #1;
    chk(rd_data_s == model[8'h22], "R8 small array unprotected write", rd_data_s, model[8'h22]);

    // R2 wrap from offset 5
    send_page(8'h45, 5, 8'h30, 16'h0, 1'b0, 1'b0, "R2 wrap");
    read_chk(8'h40, model[8'h40], "R2 wrapped slot 0");
    read_chk(8'h48, 8'h00, "R2 next page untouched");

    // R3 eleven bytes: last eight survive
    send_page(8'h18, 11, 8'h50, 16'h0, 1'b0, 1'b0, "R3 overfill");
    read_chk(8'h18, 8'(8'h50 + 8 * 7), "R3 slot0 last byte");
    read_chk(8'h1B, 8'(8'h50 + 3 * 7), "R3 slot3 earlier byte");

    // R12 ends on slot 7
    send_page(8'h33, 5, 8'h70, 16'h0, 1'b0, 1'b0, "R12 end of page");
    chk(cur_addr == 8'h30, "R12 pointer wraps to page start", cur_addr, 8'h30);

    // R7 dummy write
    send_page(8'h77, 0, 8'h00, 16'h0, 1'b0, 1'b0, "R7 dummy no busy");

    // R13 all protected in upper half
    send_page(8'h90, 4, 8'h90, 16'hF, 1'b0, 1'b0, "R13 protected cycle length");
    read_chk(8'h90, 8'h00, "R13 array unchanged");

    // R9 per-byte sampling
    send_page(8'hA0, 6, 8'hA1, 16'b010101, 1'b0, 1'b0, "R9 mixed");
    read_chk(8'hA0, 8'h00, "R9 protected slot dropped");
    read_chk(8'hA1, 8'(8'hA1 + 7), "R9 unprotected slot written");

    // R8 lower half with wp high: big writes, small blocks
    send_page(8'h08, 2, 8'hC3, 16'h3, 1'b0, 1'b0, "R8 lower half");
    read_chk(8'h08, 8'hC3, "R8 lower half written");
    rd_addr = 8'h08; #1;
    chk(rd_data_s == 8'h00, "R8 small array fully protected", rd_data_s, 8'h00);

    // R10 wp rises mid-cycle
    send_page(8'h28, 2, 8'hD0, 16'h0, 1'b1, 1'b0, "R10 wp mid-cycle");
    read_chk(8'h29, 8'(8'hD0 + 7), "R10 write landed");

    // R11 reads with wp high
    @(negedge clk);
    wp = 1'b1;
    read_chk(8'h21, model[8'h21], "R11 read with wp high");
    read_chk(8'hA1, model[8'hA1], "R11 read upper with wp high");
    wp = 1'b0;

    // R6 commands during busy ignored
    send_page(8'h50, 2, 8'hE0, 16'h0, 1'b0, 1'b1, "R6 busy lockout");
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R6 busy stays low", busy, 0);
    chk(cur_addr == 8'h52, "R6 pointer unchanged", cur_addr, 8'h52);
    chk(exp_a.size() == 0, "R5 all expected writes seen", exp_a.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule